// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes an 8-bit controller presents to external memory: an active-high address-latch pulse and an active-low program-store read strobe. It runs from the oscillator-rate clock. A free-running phase counter splits every machine cycle into twelve oscillator periods, which are six internal states of two periods each. Each strobe is decoded from the phase and from a small context word, and then registered so the pins are free of glitches.

The controller core supplies four per-cycle flags: external code execution, an external data access in this machine cycle, a code-table read, and a software bit that silences the address-latch pulse. The flags are captured once per machine cycle, on the clock edge that ends the last phase. A whole cycle therefore sees one consistent context. Data cycles remove some strobes in a fixed pattern. The silence bit is overridden whenever the pulse is actually needed.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: While `rst_i` is high, `ale_o` is 0 and `psen_n_o` is 1 from the next clock edge on, and the phase counter returns to phase 0.
- R2: A machine cycle is 12 clocks, phases 0 to 11, and the first clock edge after reset release starts phase 0. The output after edge n shows the decode of phase (n-1) mod 12. When ALE is enabled, `ale_o` is 1 in phases 0, 1, 6 and 7 and 0 in the other phases.
- R3: When external code is flagged and no data access is flagged, `psen_n_o` is 0 in phases 3, 4, 5, 9, 10 and 11 and 1 elsewhere.
- R4: When external code is not flagged, `psen_n_o` stays 1 for the whole cycle.
- R5: In a cycle flagged as an external data access, the second ALE pulse (phases 6 and 7) is dropped and the first pulse is kept.
- R6: In a cycle flagged as an external data access with external code, both read-strobe activations are dropped and `psen_n_o` stays 1.
- R7: With `ale_off_i` set, external code clear, and no data access or table read flagged, `ale_o` is held at 1 for the whole cycle.
- R8: With external code flagged, `ale_off_i` has no effect: `ale_o` pulses exactly as in R2 and R5.
- R9: With `ale_off_i` set and either a data access or a table read flagged, ALE pulses as in R2 and R5.
- R10: The flags are sampled only on the edge that ends phase 11. While reset is high they are sampled on every edge. A flag change in the middle of a cycle does not alter that cycle's strobes.
- R11: `ale_o` high and `psen_n_o` low never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_code_i | input | 1 | Code is being fetched from external program memory |
| xdata_cyc_i | input | 1 | The coming machine cycle is an external data access |
| table_rd_i | input | 1 | The coming machine cycle is a code-table read |
| ale_off_i | input | 1 | Software bit that silences ALE outside external accesses |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-store read strobe, active low |

## Verification
The hardest case to reach is a flag that changes in the middle of a machine cycle, because a correct design must ignore that change until the cycle boundary. The stimulus switches from internal to external execution at phase 3, which is the first read-strobe slot. It then checks that no read strobe appears for the rest of that cycle and that strobes do appear in the next one. A reset asserted in mid-cycle is also applied, and the bench checks that the cycle realigns to phase 0 after release. The silence-bit combinations are walked cycle by cycle, including the change from a held-high ALE back to normal pulsing.

// File: rtl/strobe_gen_pkg.sv
package strobe_gen_pkg;

    // Default timing: two oscillator periods per state, six states per cycle
    localparam int unsigned DEF_OSC_PER_STATE = 2;
    localparam int unsigned DEF_STATES        = 6;
    localparam int unsigned DEF_ALE_HI        = 2;
    localparam int unsigned DEF_PSEN_LO       = 3;

    // Per-cycle context captured at the machine-cycle boundary
    typedef struct packed {
        logic ext_code;
        logic xdata;
        logic table_rd;
        logic ale_off;
    } cyc_ctx_t;

    // Decoded strobe levels for one phase
    typedef struct packed {
        logic ale;
        logic psen_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ale: 1'b0, psen_n: 1'b1};

    function automatic logic ale_enabled(cyc_ctx_t c);
        return c.ext_code | ~c.ale_off | c.xdata | c.table_rd;
    endfunction

endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr #(
    parameter int unsigned PHASES = 12,
    parameter int unsigned PH_W   = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    output logic [PH_W-1:0] ph_o,
    output logic            wrap_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    assign wrap_o = (ph_o == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i)       ph_o <= '0;
        else if (wrap_o) ph_o <= '0;
        else             ph_o <= ph_o + 1'b1;
    end
endmodule

// File: rtl/bus_cycle_ctx.sv
module bus_cycle_ctx
    import strobe_gen_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     wrap_i,
    input  cyc_ctx_t ctx_i,
    output cyc_ctx_t ctx_o
);
    // Reload on every reset edge and at each cycle boundary
    always_ff @(posedge clk_i) begin
        if (rst_i || wrap_i) ctx_o <= ctx_i;
    end
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import strobe_gen_pkg::*;
#(
    parameter int unsigned OSC_PER_STATE = DEF_OSC_PER_STATE,
    parameter int unsigned STATES        = DEF_STATES,
    parameter int unsigned ALE_HI        = DEF_ALE_HI,
    parameter int unsigned PSEN_LO       = DEF_PSEN_LO,
    parameter int unsigned PH_W          = 4
) (
    input  logic [PH_W-1:0] ph_i,
    input  cyc_ctx_t        ctx_i,
    output strobe_t         strb_o,
    output logic            ale_en_o
);
    localparam int unsigned HALF = OSC_PER_STATE * STATES / 2;
    localparam logic [PH_W-1:0] HALF_PH  = PH_W'(HALF);
    localparam logic [PH_W-1:0] ALE_END  = PH_W'(ALE_HI);
    localparam logic [PH_W-1:0] PSEN_BEG = PH_W'(HALF - PSEN_LO);

    logic            second;
    logic [PH_W-1:0] pos;
    logic            ale_slot;
    logic            psen_slot;
    logic            ale_drop;

    always_comb begin
        second    = (ph_i >= HALF_PH);
        pos       = second ? (ph_i - HALF_PH) : ph_i;
        ale_slot  = (pos < ALE_END);
        psen_slot = (pos >= PSEN_BEG);
        ale_en_o  = ale_enabled(ctx_i);
        // A data access takes the bus in the second half: its latch pulse goes
        ale_drop  = ctx_i.xdata & second;
        strb_o.ale    = ale_en_o ? (ale_slot & ~ale_drop) : 1'b1;
        strb_o.psen_n = ~(ctx_i.ext_code & ~ctx_i.xdata & psen_slot);
    end
endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
    import strobe_gen_pkg::*;
#(
    parameter int unsigned OSC_PER_STATE = DEF_OSC_PER_STATE,
    parameter int unsigned STATES        = DEF_STATES,
    parameter int unsigned ALE_HI        = DEF_ALE_HI,
    parameter int unsigned PSEN_LO       = DEF_PSEN_LO
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ext_code_i,
    input  logic xdata_cyc_i,
    input  logic table_rd_i,
    input  logic ale_off_i,
    output logic ale_o,
    output logic psen_n_o
);
    localparam int unsigned PHASES = OSC_PER_STATE * STATES;
    localparam int unsigned PH_W   = $clog2(PHASES);

    logic [PH_W-1:0] ph_w;
    logic            wrap_w;
    cyc_ctx_t        ctx_in_w;
    cyc_ctx_t        ctx_q;
    strobe_t         strb_w;
    logic            ale_en_w;
    logic            ext_q_w;

    assign ctx_in_w = '{ext_code: ext_code_i, xdata: xdata_cyc_i,
                        table_rd: table_rd_i, ale_off: ale_off_i};
    assign ext_q_w  = ctx_q.ext_code;

    bus_phase_ctr #(.PHASES(PHASES), .PH_W(PH_W)) phase_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ph_o  (ph_w),
        .wrap_o(wrap_w)
    );

    bus_cycle_ctx ctx_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .wrap_i(wrap_w),
        .ctx_i (ctx_in_w),
        .ctx_o (ctx_q)
    );

    strobe_decode #(
        .OSC_PER_STATE(OSC_PER_STATE), .STATES(STATES),
        .ALE_HI(ALE_HI), .PSEN_LO(PSEN_LO), .PH_W(PH_W)
    ) dec_i (
        .ph_i    (ph_w),
        .ctx_i   (ctx_q),
        .strb_o  (strb_w),
        .ale_en_o(ale_en_w)
    );

    // Registered pins: one clock behind the phase decode
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ale_o    <= STROBE_IDLE.ale;
            psen_n_o <= STROBE_IDLE.psen_n;
        end else begin
            ale_o    <= strb_w.ale;
            psen_n_o <= strb_w.psen_n;
        end
    end
endmodule

// File: rtl/ext_bus_strobe_gen_chk.sv
module ext_bus_strobe_gen_chk (
    input logic clk,
    input logic rst,
    input logic ale_o,
    input logic psen_n_o,
    input logic ale_en,
    input logic ext_q
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!ale_o && psen_n_o));

    a_r2_ale_two_clocks: assert property (@(posedge clk) disable iff (rst)
        ($rose(ale_o) && ale_en) |=> ale_o ##1 !ale_o);

    a_r3_psen_three_clocks: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n_o) |=> !psen_n_o ##1 !psen_n_o ##1 psen_n_o);

    a_r4_internal_no_psen: assert property (@(posedge clk) disable iff (rst)
        $past(!ext_q) |-> psen_n_o);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ale_o && !psen_n_o));
endmodule

bind ext_bus_strobe_gen ext_bus_strobe_gen_chk chk_i (
    .clk     (clk_i),
    .rst     (rst_i),
    .ale_o   (ale_o),
    .psen_n_o(psen_n_o),
    .ale_en  (ale_en_w),
    .ext_q   (ext_q_w)
);

// File: tb/ext_bus_strobe_gen_tb_top.sv
module ext_bus_strobe_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] stim = 4'b0000;   // {ext, xdata, table, ale_off}
    logic       ale, psen_n;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ext_bus_strobe_gen dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .ext_code_i (stim[3]),
        .xdata_cyc_i(stim[2]),
        .table_rd_i (stim[1]),
        .ale_off_i  (stim[0]),
        .ale_o      (ale),
        .psen_n_o   (psen_n)
    );

    localparam int NV = 11;
    localparam logic [3:0] VEC [NV] = '{
        4'b1000,  // R2 R3 external fetch
        4'b0000,  // R4 internal
        4'b1100,  // R5 R6 external with data access
        4'b0100,  // R5 internal with data access
        4'b0001,  // R7 ALE silenced
        4'b1001,  // R8 silence ignored
        4'b0011,  // R9 table read
        4'b0101,  // R9 data access
        4'b1000,
        4'b0001,
        4'b0000
    };

    function automatic logic [1:0] model(int p, logic [3:0] v);
        logic ext, xd, tb, off, sec, en, a, pn;
        int   pos;
        ext = v[3]; xd = v[2]; tb = v[1]; off = v[0];
        sec = (p >= 6);
        pos = p % 6;
        en  = ext | ~off | xd | tb;
        a   = en ? ((pos < 2) && !(xd && sec)) : 1'b1;
        pn  = !(ext && !xd && pos >= 3);
        return {a, pn};
    endfunction

    function automatic string tag(logic [3:0] v);
        if (v[0] && !v[3] && !v[2] && !v[1]) return "R7";
        if (v[0] && v[3])                    return "R8";
        if (v[0])                            return "R9";
        if (v[2] && v[3])                    return "R6";
        if (v[2])                            return "R5";
        if (v[3])                            return "R3";
        return "R4";
    endfunction

    task automatic check(string req, logic [1:0] exp);
        n_chk++;
        if ({ale, psen_n} !== exp) begin
            n_fail++;
            $display("FAIL %s: ale/psen_n got %b%b expected %b", req, ale, psen_n, exp);
        end
    endtask

    // One machine cycle; optional mid-cycle stimulus change at step mid_k
    task automatic run_cycle(logic [3:0] v, logic [3:0] nxt, int mid_k,
                             logic [3:0] mid_v, string req);
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(req, model(k, v));
            if (k == mid_k) stim = mid_v;
            if (k == 10)    stim = nxt;
        end
    endtask

    initial begin : wd
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        stim = VEC[0];
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 2'b01);
        rst = 1'b0;

        for (int v = 0; v < NV; v++)
            run_cycle(VEC[v], (v + 1 < NV) ? VEC[v + 1] : 4'b0000, -1, 4'b0000, tag(VEC[v]));

        // R10: switch to external code at phase 3; this cycle stays internal
        run_cycle(4'b0000, 4'b1000, 2, 4'b1000, "R10");
        run_cycle(4'b1000, 4'b1000, -1, 4'b0000, "R10");

        // R1: reset in mid-cycle, then realign to phase 0 (R2)
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst  = 1'b1;
        stim = 4'b1100;
        @(posedge clk);
        @(negedge clk);
        check("R1", 2'b01);
        @(posedge clk);
        @(negedge clk);
        check("R1", 2'b01);
        rst = 1'b0;
        run_cycle(4'b1100, 4'b1000, -1, 4'b0000, "R6");
        run_cycle(4'b1000, 4'b0000, -1, 4'b0000, "R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule